// File: doc/BRIEF.md
# Tick Counter with Compare

This block keeps a running tick count and raises a flag when that count reaches a limit that software has programmed. Software reaches it through a small register port: a write strobe, a read strobe, a 2-bit address and 64-bit data. The counter advances by one on every clock where the count-enable input is high. The top bit of every value written to the count or the limit is not part of the value. It is a shared "timer disabled" flag, and reads show it again in that same top bit.

A limit write arms a one-shot compare, but only when the value is nonzero and the disable bit is clear. When the counter steps onto the armed limit, the match flag in a small software-interrupt register is set. If the limit is already at or behind the count when it is written, the match happens on the next counting step and does not wait for the counter to wrap around. The flag stays set until software pulses a clear input. Any write that sets the disable bit disarms the compare.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 0, the limit is 0, the compare is disarmed, the match flag is 0 and the timer is disabled, so a read of address 0 or 1 returns 0x8000_0000_0000_0000.
- R2: A write to address 0 loads bits 62:0 of the data into the counter and copies bit 63 into the disabled flag.
- R3: The counter adds one at each clock edge where tick_en is high and wr_en is low, wrapping from 2^63-1 to 0; a cycle with wr_en high never counts.
- R4: With rd_en high, rdata returns, by address: 0 the count with bit 63 set to the disabled flag; 1 the limit with bit 63 set to the disabled flag; 2 the match flag in bit 0 and zeros above it; 3 zero. With rd_en low, rdata is 0.
- R5: A write to address 1 stores bits 62:0 as the limit and copies bit 63 into the disabled flag. It arms the compare only if bits 62:0 are nonzero and bit 63 is clear. A count write never arms the compare.
- R6: When the compare is armed and a counting cycle moves the count onto the limit, match_flag becomes 1 at that edge and the compare disarms, so the match fires once.
- R7: A limit that is armed and is less than or equal to the count at the moment it is written fires at the first following counting cycle.
- R8: A limit write whose bits 62:0 are zero produces no match.
- R9: Any write with bit 63 set disarms the compare, so no match follows while the timer is disabled.
- R10: match_flag holds until a cycle with match_clr high. If a match and match_clr fall in the same cycle, the match wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 count, 1 limit, 2 interrupt) |
| wdata | input | 64 | Write data; bit 63 is the disable bit |
| rdata | output | 64 | Read data, combinational while rd_en is high |
| match_clr | input | 1 | Write-one-to-clear strobe for the match flag |
| match_flag | output | 1 | Timer-match bit of the software-interrupt register |

## Verification
The properties assume that the strobes are clean single-cycle levels, sampled on the rising edge. They also assume that a read is judged against the state left by the previous edge, and that nothing is written to the registers during the first cycles after reset, while the internal reset is still being released. The stimulus drives every input just after a rising edge and leaves tick_en low in every read and flag-check cycle, so each expected value follows from a known count. The bench waits several cycles after reset before its first write.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    ADR_COUNT   = 2'd0,
    ADR_LIMIT   = 2'd1,
    ADR_SOFTINT = 2'd2,
    ADR_RSVD    = 2'd3
  } tick_addr_e;
endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int VAL_W = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VAL_W-1:0] load_val,
  input  logic             step,
  output logic [VAL_W-1:0] cnt,
  output logic [VAL_W-1:0] cnt_inc
);
  logic [VAL_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_inc = cnt + 1'b1;
    cnt_en  = load | step;
    cnt_d   = load ? load_val : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int VAL_W = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lim_wr,
  input  logic             cnt_wr,
  input  logic [VAL_W-1:0] wval,
  input  logic             wdis,
  input  logic [VAL_W-1:0] cnt,
  input  logic [VAL_W-1:0] cnt_inc,
  input  logic             eval,
  output logic [VAL_W-1:0] lim,
  output logic             fire
);
  logic [VAL_W-1:0] lim_d;
  logic             armed, armed_d;
  logic             late, late_d;
  logic             upd;

  always_comb begin
    lim_d   = lim;
    armed_d = armed;
    late_d  = late;
    fire    = eval && armed && (late || (cnt_inc == lim));
    if (lim_wr) begin
      lim_d   = wval;
      armed_d = (wval != '0) && !wdis;
      late_d  = (wval <= cnt);
    end else if (cnt_wr) begin
      if (wdis) armed_d = 1'b0;
      late_d = (lim <= wval);
    end else if (fire) begin
      armed_d = 1'b0;
      late_d  = 1'b0;
    end
    upd = lim_wr | cnt_wr | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim   <= '0;
      armed <= 1'b0;
      late  <= 1'b0;
    end else if (upd) begin
      lim   <= lim_d;
      armed <= armed_d;
      late  <= late_d;
    end
  end
endmodule

// File: rtl/tick_rdmux.sv
module tick_rdmux
  import tick_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-2:0] cnt,
  input  logic [CNT_W-2:0] lim,
  input  logic             dis,
  input  logic             flag,
  output logic [CNT_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (tick_addr_e'(addr))
        ADR_COUNT:   rdata = {dis, cnt};
        ADR_LIMIT:   rdata = {dis, lim};
        ADR_SOFTINT: rdata = {{(CNT_W-1){1'b0}}, flag};
        default:     rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             match_clr,
  output logic             match_flag
);
  localparam int VAL_W = CNT_W - 1;

  logic             rst_n_i;
  logic             cnt_wr, lim_wr, eval, fire;
  logic [VAL_W-1:0] cnt, cnt_inc, lim;
  logic             dis, dis_d, dis_en;
  logic             flag_d, flag_en;

  tick_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  always_comb begin
    cnt_wr  = wr_en && (tick_addr_e'(addr) == ADR_COUNT);
    lim_wr  = wr_en && (tick_addr_e'(addr) == ADR_LIMIT);
    eval    = tick_en && !wr_en;
    dis_en  = cnt_wr | lim_wr;
    dis_d   = wdata[CNT_W-1];
    flag_en = fire | match_clr;
    flag_d  = fire;
  end

  tick_counter #(.VAL_W(VAL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .load(cnt_wr), .load_val(wdata[VAL_W-1:0]),
    .step(eval), .cnt(cnt), .cnt_inc(cnt_inc)
  );

  tick_compare #(.VAL_W(VAL_W)) u_cmp (
    .clk(clk), .rst_n(rst_n_i), .lim_wr(lim_wr), .cnt_wr(cnt_wr),
    .wval(wdata[VAL_W-1:0]), .wdis(wdata[CNT_W-1]), .cnt(cnt),
    .cnt_inc(cnt_inc), .eval(eval), .lim(lim), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)    dis <= 1'b1;
    else if (dis_en) dis <= dis_d;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)     match_flag <= 1'b0;
    else if (flag_en) match_flag <= flag_d;
  end

  tick_rdmux #(.CNT_W(CNT_W)) u_rd (
    .rd_en(rd_en), .addr(addr), .cnt(cnt), .lim(lim), .dis(dis),
    .flag(match_flag), .rdata(rdata)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] rdata,
  input logic             match_clr,
  input logic             match_flag
);
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !match_clr) |=> match_flag);

  // R6
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(tick_en && !wr_en));

  // R8
  zero_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && wdata[CNT_W-2:0] == '0) |=> ##1 !$rose(match_flag));

  // R9
  dis_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1] == 1'b0 && wdata[CNT_W-1]) |=> ##1 !$rose(match_flag));

  // R2
  dis_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[CNT_W-1])
      |=> (!(rd_en && addr == 2'd0) || rdata[CNT_W-1]));

  // R4
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .match_clr(match_clr),
  .match_flag(match_flag)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, match_clr = 1'b0;
  logic [1:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        match_flag;
  logic        smp = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer #(.CNT_W(64)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .match_clr(match_clr),
    .match_flag(match_flag)
  );

  // monitor: pops expected items and compares in the middle of the cycle
  always @(negedge clk) begin
    if (smp && exp_q.size() > 0) begin
      logic [63:0] e, a;
      bit k;
      string t;
      e = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      a = k ? {63'b0, match_flag} : rdata;
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic drive(bit w, bit r, logic [1:0] a, logic [63:0] d, bit tk, bit clr);
    @(posedge clk); #1;
    wr_en = w; rd_en = r; addr = a; wdata = d; tick_en = tk; match_clr = clr;
    smp = 1'b0;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [63:0] d);
    drive(1, 0, a, d, 0, 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 2'd0, '0, 1, 0);
  endtask

  task automatic rd_chk(logic [1:0] a, logic [63:0] e, string t);
    drive(0, 1, a, '0, 0, 0);
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
    smp = 1'b1;
  endtask

  task automatic flag_chk(bit e, string t);
    drive(0, 0, 2'd0, '0, 0, 0);
    exp_q.push_back({63'b0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
    smp = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);

    rd_chk(2'd0, DIS, "R1 count after reset");
    rd_chk(2'd1, DIS, "R1 limit after reset");
    flag_chk(0, "R1 flag after reset");

    wr_reg(2'd0, 64'd100);
    rd_chk(2'd0, 64'd100, "R2 count load enabled");
    ticks(5);
    rd_chk(2'd0, 64'd105, "R3 count advance");

    wr_reg(2'd1, 64'd110);
    ticks(4);
    flag_chk(0, "R6 no match before limit");
    ticks(1);
    flag_chk(1, "R6 match at limit");
    rd_chk(2'd1, 64'd110, "R4 limit readback");
    drive(0, 0, 2'd0, '0, 0, 1);
    flag_chk(0, "R10 clear");
    ticks(3);
    flag_chk(0, "R6 one shot");
    rd_chk(2'd0, 64'd113, "R3 count keeps running");

    wr_reg(2'd1, 64'd50);
    flag_chk(0, "R7 late limit waits for tick");
    ticks(1);
    flag_chk(1, "R7 late limit fires");
    drive(0, 0, 2'd0, '0, 0, 1);

    wr_reg(2'd1, 64'd0);
    ticks(3);
    flag_chk(0, "R8 zero limit");
    rd_chk(2'd1, 64'd0, "R5 zero limit enabled");

    wr_reg(2'd1, DIS | 64'd118);
    ticks(3);
    flag_chk(0, "R9 disabled limit");
    rd_chk(2'd0, DIS | 64'd120, "R4 count shows disable");
    rd_chk(2'd1, DIS | 64'd118, "R5 limit stores disable");

    wr_reg(2'd0, 64'd200);
    rd_chk(2'd0, 64'd200, "R2 count write enables");
    ticks(20);
    flag_chk(0, "R5 count write does not arm");

    wr_reg(2'd1, 64'd225);
    wr_reg(2'd0, DIS | 64'd205);
    ticks(25);
    flag_chk(0, "R9 count write disarms");
    rd_chk(2'd0, DIS | 64'd230, "R2 disable recorded");

    wr_reg(2'd0, 64'd300);
    wr_reg(2'd1, 64'd302);
    ticks(1);
    drive(0, 0, 2'd0, '0, 1, 1);
    flag_chk(1, "R10 set wins over clear");
    rd_chk(2'd2, 64'd1, "R4 interrupt register");
    drive(0, 0, 2'd0, '0, 0, 1);
    rd_chk(2'd2, 64'd0, "R10 cleared in interrupt register");
    rd_chk(2'd3, 64'd0, "R4 reserved address");

    drive(1, 0, 2'd0, 64'd400, 1, 0);
    rd_chk(2'd0, 64'd400, "R3 write beats tick");

    wr_reg(2'd0, 64'h7FFF_FFFF_FFFF_FFFE);
    ticks(2);
    rd_chk(2'd0, 64'd0, "R3 wrap");

    wr_reg(2'd0, 64'd500);
    wr_reg(2'd1, 64'd500);
    flag_chk(0, "R7 equal limit waits");
    ticks(1);
    flag_chk(1, "R7 equal limit fires");

    drive(0, 0, 2'd0, '0, 0, 0);
    @(posedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule